// File: doc/BRIEF.md
# Switch Mirror and Date Display Panel

This block is a purely combinational front panel. Eight slide switches are reflected onto eight LEDs with inverted polarity, so an LED is lit while its switch sits at logic 0. Holding an invert button flips all eight LED outputs at once. Six seven-segment digits show a fixed calendar date as two-digit month, day and year. Holding a second button swaps that date for an alternate one.

Both dates are parameters, each written as six BCD nibbles. The most significant nibble is the tens digit of the month and drives the leftmost digit. Each digit goes through its own instance of a reusable nibble-to-segment decoder. The block has no clock and no state, so a change on a switch or button reaches the outputs within the same evaluation.

Top module: `switch_date_panel`

## Requirements
- R1: With the invert button released (`inv_btn_n` = 1), `led_o[i]` is 1 (lit) exactly when `sw_i[i]` is 0, for every bit i.
- R2: With the invert button held (`inv_btn_n` = 0), every LED output is the complement of its R1 value, so `led_o` equals `sw_i`.
- R3: With the alternate button released (`alt_btn_n` = 1), the digits show `DATE_A`. Nibble [23:20] drives `disp5_n` (the leftmost digit, month tens) and so on down to nibble [3:0] on `disp0_n`. The default `DATE_A` of 24'h040199 reads 040199.
- R4: With the alternate button held (`alt_btn_n` = 0), the digits show `DATE_B` in the same nibble-to-digit order.
- R5: A digit output is active low: bit 0 is segment a through bit 6 is segment g. Values 0 to 9 give, in hex, 40, 79, 24, 30, 19, 12, 02, 78, 00, 10.
- R6: A nibble value from 10 to 15 blanks its digit, which means all seven outputs are 1.
- R7: The alternate button has no effect on `led_o`. The switches and the invert button have no effect on the digits.
- R8: Outputs follow input changes combinationally. No clock edge is needed between a change and its effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sw_i | input | LED_W | Slide switch levels |
| inv_btn_n | input | 1 | Invert button, 0 while held |
| alt_btn_n | input | 1 | Alternate-date button, 0 while held |
| led_o | output | LED_W | LED drive, 1 = lit |
| disp5_n | output | 7 | Leftmost digit, segments g..a, active low |
| disp4_n | output | 7 | Digit 4, segments g..a, active low |
| disp3_n | output | 7 | Digit 3, segments g..a, active low |
| disp2_n | output | 7 | Digit 2, segments g..a, active low |
| disp1_n | output | 7 | Digit 1, segments g..a, active low |
| disp0_n | output | 7 | Rightmost digit, segments g..a, active low |

## Verification
The blanking of digits cannot be reached through the ports of the default instance, because both default dates hold only decimal digits. The bench therefore adds a second instance whose alternate date is set to 24'hABCDEF, which drives the six non-decimal codes. Its main date is 24'h987654, so the two instances together cover every decimal pattern. The remaining hard case is independence between the two paths. The bench holds each button while it sweeps the inputs that belong to the other path, and it confirms that the outputs of that other path stay unchanged.

// File: rtl/panel_pkg.sv
// Package: shared widths and segment constants for the panel.
// Assumes seven segments per digit, ordered g..a, active low.
package panel_pkg;
    localparam int SEG_W   = 7;
    localparam int NIB_W   = 4;
    localparam int DIGITS  = 6;
    localparam int DATE_W  = DIGITS * NIB_W;
    localparam logic [SEG_W-1:0] SEG_BLANK = '1;
    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [NIB_W-1:0] nib_t;
endpackage

// File: rtl/seg_decoder.sv
// Module: converts one BCD nibble to an active-low segment pattern.
// Assumes bit 0 = segment a, bit 6 = segment g; codes 10..15 blank.
module seg_decoder
    import panel_pkg::*;
(
    input  nib_t value_i,
    output seg_t seg_n_o
);
    // Purpose: table lookup from digit value to lit segments.
    always_comb begin
        case (value_i)
            4'd0:    seg_n_o = 7'h40;
            4'd1:    seg_n_o = 7'h79;
            4'd2:    seg_n_o = 7'h24;
            4'd3:    seg_n_o = 7'h30;
            4'd4:    seg_n_o = 7'h19;
            4'd5:    seg_n_o = 7'h12;
            4'd6:    seg_n_o = 7'h02;
            4'd7:    seg_n_o = 7'h78;
            4'd8:    seg_n_o = 7'h00;
            4'd9:    seg_n_o = 7'h10;
            default: seg_n_o = SEG_BLANK;
        endcase
    end
endmodule

// File: rtl/led_mirror.sv
// Module: drives LEDs as the inverse of the switches, flipped again
// while the invert button is held. Assumes an active-low button.
module led_mirror #(
    parameter int LED_W = 8
) (
    input  logic [LED_W-1:0] sw_i,
    input  logic             inv_btn_n,
    output logic [LED_W-1:0] led_o
);
    logic flip;
    // Purpose: a held button cancels the normal inversion.
    assign flip = ~inv_btn_n;

    for (genvar i = 0; i < LED_W; i++) begin : g_bit
        // Purpose: per-bit polarity, lit on switch low unless flipped.
        assign led_o[i] = ~sw_i[i] ^ flip;
    end
endmodule

// File: rtl/date_picker.sv
// Module: chooses one of two parameter dates and splits it into
// digit nibbles, index 5 = month tens. Assumes active-low select.
module date_picker
    import panel_pkg::*;
#(
    parameter logic [DATE_W-1:0] DATE_A = 24'h040199,
    parameter logic [DATE_W-1:0] DATE_B = 24'h235678
) (
    input  logic             alt_btn_n,
    output nib_t [DIGITS-1:0] nib_o
);
    logic [DATE_W-1:0] chosen;
    // Purpose: pick the alternate date only while its button is held.
    assign chosen = alt_btn_n ? DATE_A : DATE_B;

    for (genvar d = 0; d < DIGITS; d++) begin : g_nib
        // Purpose: slice nibble d of the chosen date.
        assign nib_o[d] = chosen[d*NIB_W +: NIB_W];
    end
endmodule

// File: rtl/switch_date_panel.sv
// Module: top of the panel. LEDs mirror switches inverted; six digits
// show one of two MMDDYY dates. Purely combinational, no clock.
module switch_date_panel
    import panel_pkg::*;
#(
    parameter int                LED_W  = 8,
    parameter logic [DATE_W-1:0] DATE_A = 24'h040199,
    parameter logic [DATE_W-1:0] DATE_B = 24'h235678
) (
    input  logic [LED_W-1:0] sw_i,
    input  logic             inv_btn_n,
    input  logic             alt_btn_n,
    output logic [LED_W-1:0] led_o,
    output logic [6:0]       disp5_n,
    output logic [6:0]       disp4_n,
    output logic [6:0]       disp3_n,
    output logic [6:0]       disp2_n,
    output logic [6:0]       disp1_n,
    output logic [6:0]       disp0_n
);
    nib_t [DIGITS-1:0] nibs;
    seg_t [DIGITS-1:0] segs;

    led_mirror #(.LED_W(LED_W)) u_mirror (
        .sw_i      (sw_i),
        .inv_btn_n (inv_btn_n),
        .led_o     (led_o)
    );

    date_picker #(.DATE_A(DATE_A), .DATE_B(DATE_B)) u_picker (
        .alt_btn_n (alt_btn_n),
        .nib_o     (nibs)
    );

    for (genvar d = 0; d < DIGITS; d++) begin : g_dig
        seg_decoder u_dec (
            .value_i (nibs[d]),
            .seg_n_o (segs[d])
        );
    end

    // Purpose: route decoded digits to the named outputs, left to right.
    assign disp5_n = segs[5];
    assign disp4_n = segs[4];
    assign disp3_n = segs[3];
    assign disp2_n = segs[2];
    assign disp1_n = segs[1];
    assign disp0_n = segs[0];
endmodule

// File: rtl/switch_date_panel_chk.sv
// Module: assertion checker bound to the panel top. Immediate checks,
// since the block has no clock. Assumes the same parameters as the top.
module switch_date_panel_chk
    import panel_pkg::*;
#(
    parameter int                LED_W  = 8,
    parameter logic [DATE_W-1:0] DATE_A = 24'h040199,
    parameter logic [DATE_W-1:0] DATE_B = 24'h235678
) (
    input logic [LED_W-1:0] sw_i,
    input logic             inv_btn_n,
    input logic             alt_btn_n,
    input logic [LED_W-1:0] led_o,
    input logic [6:0]       disp5_n,
    input logic [6:0]       disp4_n,
    input logic [6:0]       disp3_n,
    input logic [6:0]       disp2_n,
    input logic [6:0]       disp1_n,
    input logic [6:0]       disp0_n
);
    seg_t [DIGITS-1:0] segs;
    assign segs = {disp5_n, disp4_n, disp3_n, disp2_n, disp1_n, disp0_n};

    // Purpose: LED polarity relative to switches and invert button.
    always_comb begin
        if (inv_btn_n)
            a_r1_led_inverse: assert (led_o == ~sw_i);
        else
            a_r2_led_follow: assert (led_o == sw_i);
    end

    // Purpose: decimal nibbles light a digit, others blank it.
    always_comb begin
        for (int d = 0; d < DIGITS; d++) begin
            if ((alt_btn_n ? DATE_A[d*NIB_W +: NIB_W] : DATE_B[d*NIB_W +: NIB_W]) > 4'd9)
                a_r6_blank_above_nine: assert (segs[d] == SEG_BLANK);
            else
                a_r5_digit_lit: assert ($countones(~segs[d]) >= 2);
        end
    end
endmodule

bind switch_date_panel switch_date_panel_chk #(
    .LED_W (LED_W), .DATE_A (DATE_A), .DATE_B (DATE_B)
) u_chk (
    .sw_i (sw_i), .inv_btn_n (inv_btn_n), .alt_btn_n (alt_btn_n),
    .led_o (led_o), .disp5_n (disp5_n), .disp4_n (disp4_n),
    .disp3_n (disp3_n), .disp2_n (disp2_n), .disp1_n (disp1_n),
    .disp0_n (disp0_n)
);

// File: tb/switch_date_panel_bench.sv
module switch_date_panel_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sw = 8'h00;
    logic       inv_n = 1'b1;
    logic       alt_n = 1'b1;
    logic [7:0] led, led_h;
    logic [6:0] d5, d4, d3, d2, d1, d0;
    logic [6:0] h5, h4, h3, h2, h1, h0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    switch_date_panel u_switch_date_panel (
        .sw_i (sw), .inv_btn_n (inv_n), .alt_btn_n (alt_n), .led_o (led),
        .disp5_n (d5), .disp4_n (d4), .disp3_n (d3),
        .disp2_n (d2), .disp1_n (d1), .disp0_n (d0)
    );

    switch_date_panel #(.DATE_A (24'h987654), .DATE_B (24'hABCDEF)) u_switch_date_panel_hex (
        .sw_i (sw), .inv_btn_n (inv_n), .alt_btn_n (alt_n), .led_o (led_h),
        .disp5_n (h5), .disp4_n (h4), .disp3_n (h3),
        .disp2_n (h2), .disp1_n (h1), .disp0_n (h0)
    );

    // Expected pattern from the R5 table, blank above nine (R6).
    function automatic logic [6:0] seg_of(input logic [3:0] v);
        case (v)
            4'd0: return 7'h40; 4'd1: return 7'h79; 4'd2: return 7'h24;
            4'd3: return 7'h30; 4'd4: return 7'h19; 4'd5: return 7'h12;
            4'd6: return 7'h02; 4'd7: return 7'h78; 4'd8: return 7'h00;
            4'd9: return 7'h10; default: return 7'h7F;
        endcase
    endfunction

    task automatic check_led(input logic [7:0] exp, input string req);
        checks++;
        if (led !== exp) begin
            errors++;
            $display("FAIL %s: led_o actual %h expected %h", req, led, exp);
        end
    endtask

    task automatic check_date(input logic hex_inst, input logic [23:0] date, input string req);
        logic [41:0] act, exp;
        act = hex_inst ? {h5, h4, h3, h2, h1, h0} : {d5, d4, d3, d2, d1, d0};
        for (int d = 0; d < 6; d++) exp[d*7 +: 7] = seg_of(date[d*4 +: 4]);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: digits actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] s, input logic i_n, input logic a_n);
        @(negedge clk);
        sw = s; inv_n = i_n; alt_n = a_n;
        #1;
    endtask

    task automatic t_reset_state;
        apply(8'h00, 1'b1, 1'b1);
        check_led(8'hFF, "R1 idle");
        check_date(1'b0, 24'h040199, "R3 idle");
    endtask

    task automatic t_mirror;
        for (int i = 0; i < 8; i++) begin
            apply(8'h01 << i, 1'b1, 1'b1);
            check_led(~(8'h01 << i), "R1 walk");
        end
        apply(8'hA5, 1'b1, 1'b1);
        check_led(8'h5A, "R1 mixed");
        apply(8'hFF, 1'b1, 1'b1);
        check_led(8'h00, "R1 all up");
    endtask

    task automatic t_invert;
        apply(8'h3C, 1'b0, 1'b1);
        check_led(8'h3C, "R2 held");
        apply(8'h00, 1'b0, 1'b1);
        check_led(8'h00, "R2 all down");
        check_date(1'b0, 24'h040199, "R7 invert leaves digits");
        apply(8'hC3, 1'b0, 1'b1);
        check_date(1'b0, 24'h040199, "R7 switches leave digits");
    endtask

    task automatic t_alternate;
        apply(8'h96, 1'b1, 1'b0);
        check_date(1'b0, 24'h235678, "R4 alternate");
        check_led(8'h69, "R7 alt leaves LEDs");
        apply(8'h96, 1'b0, 1'b0);
        check_led(8'h96, "R7 both held LEDs");
        check_date(1'b0, 24'h235678, "R4 both held");
    endtask

    task automatic t_hex_blank;
        apply(8'h00, 1'b1, 1'b1);
        check_date(1'b1, 24'h987654, "R5 decimal set");
        apply(8'h00, 1'b1, 1'b0);
        check_date(1'b1, 24'hABCDEF, "R6 blanked");
    endtask

    task automatic t_comb;
        @(posedge clk);
        #2;
        alt_n = 1'b0; inv_n = 1'b0; sw = 8'h0F;
        #1;
        check_date(1'b0, 24'h235678, "R8 no edge digits");
        check_led(8'h0F, "R8 no edge LEDs");
        alt_n = 1'b1;
        #1;
        check_date(1'b0, 24'h040199, "R8 release");
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_mirror();
        t_invert();
        t_alternate();
        t_hex_blank();
        t_comb();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule